// File: doc/BRIEF.md
# Indirect Register-Window Bridge

This block is a configuration-space capability that gives a host a way into a device's memory-mapped register space without mapping that space. Software first programs three fields: a region selector, a byte offset and an access length. It then touches a 32-bit data window. Each touch of the window is checked against the programmed fields. A touch that passes the check becomes exactly one transaction on a request/acknowledge register bus. The host side stalls, with its ready output low, until that transaction completes.

The width of the backend transaction is set by the programmed length and not by the byte enables of the host access. A write lands in the window under the host byte enables. The low "length" bytes of the window then go to the backend. A read fills the low "length" bytes of the window from the backend, clears the other bytes, and returns the enabled bytes to the host. The three fields are never checked when they are written, because software may pass through invalid combinations while it sets them up. The check happens only when the window is touched.

A small byte-addressed register file stands in for the backend inside the top module. It has a fixed acknowledge latency, so the whole path can be exercised through the host port alone.

Top module: `cfg_window_bridge`

## Requirements
- R1: Host accesses select a register with `cfg_sel`: 0 is the region selector (8 bits, in byte 0), 1 is the offset (32 bits), 2 is the length (32 bits) and 3 is the data window. All of them reset to 0. Writes to selects 0 to 2 are always stored, merged under `cfg_be`, and are never checked or rejected. Reads of them return the stored value with the bytes not enabled forced to zero. Any write returns zero on `cfg_rdata`.
- R2: A window access is valid only when the region selector is 0.
- R3: A window access is valid only when offset < BAR_SIZE and offset + length <= BAR_SIZE. Both comparisons are made at full 33-bit width, so a large offset cannot wrap around.
- R4: A window access is valid only when the length is exactly 1, 2 or 4.
- R5: A window access is valid only when the offset is a whole multiple of the length.
- R6: On a valid window write, the window register first takes the enabled bytes of `cfg_wdata`. One backend write then places window byte i at address offset+i, for every i below length, whatever `cfg_be` was.
- R7: On a valid window read, one backend read loads the low length bytes of the window from addresses offset+i and clears the remaining window bytes. `cfg_rdata` returns the window with the bytes not enabled in `cfg_be` forced to zero.
- R8: On an invalid window access (read or write), no backend transaction is made and neither the window nor the register file changes. `cfg_rdata` is zero and `cfg_reject` is high for exactly the single completion cycle.
- R9: Each request completes with `cfg_ready` high for one cycle. For a field access or a rejected access, ready rises one cycle after the request is seen. For a valid window access, ready stays low until the backend acknowledges and rises in the cycle after that acknowledge. Each valid window access makes exactly one backend transaction.
- R10: The backend register file resets to all zeros and acknowledges a request ACK_LAT cycles after the request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Host request. The host holds it and all other host inputs steady until it sees `cfg_ready` |
| cfg_write | input | 1 | 1 for a write, 0 for a read |
| cfg_sel | input | 2 | Register select: 0 selector, 1 offset, 2 length, 3 window |
| cfg_be | input | 4 | Host byte enables |
| cfg_wdata | input | 32 | Host write data |
| cfg_ready | output | 1 | One-cycle completion strobe |
| cfg_rdata | output | 32 | Read data, valid while `cfg_ready` is high |
| cfg_reject | output | 1 | Window access refused, valid while `cfg_ready` is high |

## Verification
The assertions check the following on every cycle: backend strobes come only in the legal 1-, 2- and 4-byte shapes, are aligned and stay inside the region; a backend request opens only after a window request; the request is held until it is acknowledged; ready is a single-cycle strobe that follows the acknowledge; and a rejection shows only in a completion cycle. Some behaviour only the bench's scenarios can show: which data actually lands in the register file, the byte-enable merge into the window, the clearing of the upper window bytes after a short read, and that a rejected write leaves both the window and the backend contents untouched. The bench shows these through its reference model and later read-backs.

// File: rtl/cfg_window_pkg.sv
// Package: shared types and byte helpers for the indirect register-window bridge.
// Assumes 32-bit host data with four byte enables.
package cfg_window_pkg;

    typedef enum logic [1:0] {
        SEL_REGION = 2'd0,
        SEL_OFFSET = 2'd1,
        SEL_LENGTH = 2'd2,
        SEL_WINDOW = 2'd3
    } win_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } win_state_e;

    // Expand four byte enables into a 32-bit bit mask.
    function automatic logic [31:0] be_to_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // Replace the enabled bytes of old_v with those of new_v.
    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be);
        logic [31:0] m;
        m = be_to_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // Byte strobes for a programmed length; zero for an illegal length.
    function automatic logic [3:0] strb_from_len(input logic [31:0] len);
        case (len)
            32'd1:   return 4'b0001;
            32'd2:   return 4'b0011;
            32'd4:   return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_window_fields.sv
// Module: storage for the region selector, offset and length fields.
// Writes are merged under byte enables and never checked; reads return
// the addressed field (zero for the window select, served elsewhere).
module cfg_window_fields
    import cfg_window_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fld_we,
    input  win_sel_e    fld_sel,
    input  logic [3:0]  fld_be,
    input  logic [31:0] fld_wdata,
    output logic [7:0]  region_q,
    output logic [31:0] offset_q,
    output logic [31:0] length_q,
    output logic [31:0] fld_rdata
);

    // Store field writes under byte enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= '0;
            offset_q <= '0;
            length_q <= '0;
        end else if (fld_we) begin
            case (fld_sel)
                SEL_REGION: if (fld_be[0]) region_q <= fld_wdata[7:0];
                SEL_OFFSET: offset_q <= merge_bytes(offset_q, fld_wdata, fld_be);
                SEL_LENGTH: length_q <= merge_bytes(length_q, fld_wdata, fld_be);
                default:    ;
            endcase
        end
    end

    // Select the addressed field for reads.
    always_comb begin
        case (fld_sel)
            SEL_REGION: fld_rdata = {24'd0, region_q};
            SEL_OFFSET: fld_rdata = offset_q;
            SEL_LENGTH: fld_rdata = length_q;
            default:    fld_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_window_check.sv
// Module: combinational legality check of the programmed window setup.
// Compares at 33 bits so offset + length cannot wrap; BAR_SIZE > 0.
module cfg_window_check
    import cfg_window_pkg::*;
#(
    parameter int BAR_SIZE = 256
) (
    input  logic [7:0]  region,
    input  logic [31:0] offset,
    input  logic [31:0] length,
    output logic        acc_ok,
    output logic [3:0]  acc_strb
);

    localparam logic [32:0] SIZE33 = 33'(BAR_SIZE);

    logic        len_ok;
    logic        aligned;
    logic [32:0] end33;

    // Length legality and alignment of the offset to the length.
    always_comb begin
        len_ok = (length == 32'd1) || (length == 32'd2) || (length == 32'd4);
        case (length)
            32'd2:   aligned = (offset[0] == 1'b0);
            32'd4:   aligned = (offset[1:0] == 2'b00);
            default: aligned = 1'b1;
        endcase
        end33 = {1'b0, offset} + {1'b0, length};
    end

    // Combine every rule into a single verdict.
    always_comb begin
        acc_ok = (region == 8'd0) && len_ok && aligned &&
                 ({1'b0, offset} < SIZE33) && (end33 <= SIZE33);
        acc_strb = strb_from_len(length);
    end

endmodule

// File: rtl/cfg_window_regfile.sv
// Module: byte-addressed register file standing in for the backend bus.
// Acknowledges ACK_LAT cycles after req rises; req is held until ack.
// Bytes addressed at or beyond BAR_SIZE are ignored and read as zero.
module cfg_window_regfile #(
    parameter int BAR_SIZE = 256,
    parameter int ACK_LAT  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        be_req,
    input  logic        be_we,
    input  logic [31:0] be_addr,
    input  logic [31:0] be_wdata,
    input  logic [3:0]  be_strb,
    output logic        be_ack,
    output logic [31:0] be_rdata
);

    localparam int AW = (BAR_SIZE > 1) ? $clog2(BAR_SIZE) : 1;
    localparam int CW = $clog2(ACK_LAT + 1);

    logic [7:0]    mem [BAR_SIZE];
    logic [CW-1:0] lat_cnt;
    logic [31:0]   lane_addr [4];
    logic [3:0]    lane_hit;

    // Per-lane byte address and range check.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_comb begin
            lane_addr[g] = be_addr + 32'(g);
            lane_hit[g]  = be_strb[g] && (lane_addr[g] < 32'(BAR_SIZE));
            be_rdata[8*g +: 8] = lane_hit[g] ? mem[lane_addr[g][AW-1:0]] : 8'd0;
        end
    end

    // Acknowledge after the programmed latency.
    always_comb be_ack = be_req && (lat_cnt == CW'(ACK_LAT - 1));

    // Count latency and commit write bytes on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            for (int i = 0; i < BAR_SIZE; i++) mem[i] <= 8'd0;
        end else if (be_req) begin
            lat_cnt <= be_ack ? '0 : lat_cnt + 1'b1;
            if (be_ack && be_we) begin
                for (int i = 0; i < 4; i++) begin
                    if (lane_hit[i]) mem[lane_addr[i][AW-1:0]] <= be_wdata[8*i +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/cfg_window_ctrl.sv
// Module: sequencer for host accesses and the data window register.
// Field and refused accesses finish in one cycle; valid window accesses
// hold the host until the backend acknowledges. The host keeps its
// inputs steady while cfg_req is high.
module cfg_window_ctrl
    import cfg_window_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_req,
    input  logic        cfg_write,
    input  win_sel_e    cfg_sel,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] fld_rdata,
    input  logic        acc_ok,
    input  logic [3:0]  acc_strb,
    input  logic        be_ack,
    input  logic [31:0] be_rdata,
    output logic        fld_we,
    output logic        cfg_ready,
    output logic [31:0] cfg_rdata,
    output logic        cfg_reject,
    output logic        be_req,
    output logic        be_we,
    output logic [31:0] be_wdata,
    output logic [3:0]  be_strb
);

    win_state_e  state_q;
    logic        we_q;
    logic        rej_q;
    logic [31:0] win_q;
    logic [31:0] rdata_q;
    logic [31:0] len_mask;

    // Mask of the bytes covered by the programmed length.
    always_comb len_mask = be_to_mask(acc_strb);

    // Drive field writes, backend request and host completion.
    always_comb begin
        fld_we     = (state_q == ST_IDLE) && cfg_req && cfg_write && (cfg_sel != SEL_WINDOW);
        be_req     = (state_q == ST_BUS);
        be_we      = we_q;
        be_wdata   = win_q;
        be_strb    = acc_strb;
        cfg_ready  = (state_q == ST_DONE);
        cfg_rdata  = rdata_q;
        cfg_reject = rej_q;
    end

    // Step the access sequence and update the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            rej_q   <= 1'b0;
            win_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cfg_req) begin
                        rej_q <= 1'b0;
                        if (cfg_sel != SEL_WINDOW) begin
                            rdata_q <= cfg_write ? 32'd0 : (fld_rdata & be_to_mask(cfg_be));
                            state_q <= ST_DONE;
                        end else if (!acc_ok) begin
                            rdata_q <= '0;
                            rej_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            rdata_q <= '0;
                            we_q    <= cfg_write;
                            if (cfg_write) win_q <= merge_bytes(win_q, cfg_wdata, cfg_be);
                            state_q <= ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (be_ack) begin
                        if (!we_q) begin
                            win_q   <= be_rdata & len_mask;
                            rdata_q <= be_rdata & len_mask & be_to_mask(cfg_be);
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    rej_q   <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_window_bridge.sv
// Module: top of the indirect register-window bridge with its backend model.
// Joins field storage, the legality check, the sequencer and the register
// file. BAR_SIZE is the region size in bytes; ACK_LAT >= 1.
module cfg_window_bridge
    import cfg_window_pkg::*;
#(
    parameter int BAR_SIZE = 256,
    parameter int ACK_LAT  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_req,
    input  logic        cfg_write,
    input  logic [1:0]  cfg_sel,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_ready,
    output logic [31:0] cfg_rdata,
    output logic        cfg_reject
);

    win_sel_e    sel_e;
    logic        fld_we;
    logic [7:0]  region_q;
    logic [31:0] offset_q;
    logic [31:0] length_q;
    logic [31:0] fld_rdata;
    logic        acc_ok;
    logic [3:0]  acc_strb;
    logic        be_req;
    logic        be_we;
    logic        be_ack;
    logic [31:0] be_addr;
    logic [31:0] be_wdata;
    logic [31:0] be_rdata;
    logic [3:0]  be_strb;

    // Decode the select and route the offset to the backend address.
    always_comb begin
        sel_e   = win_sel_e'(cfg_sel);
        be_addr = offset_q;
    end

    cfg_window_fields u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_we    (fld_we),
        .fld_sel   (sel_e),
        .fld_be    (cfg_be),
        .fld_wdata (cfg_wdata),
        .region_q  (region_q),
        .offset_q  (offset_q),
        .length_q  (length_q),
        .fld_rdata (fld_rdata)
    );

    cfg_window_check #(.BAR_SIZE(BAR_SIZE)) u_check (
        .region   (region_q),
        .offset   (offset_q),
        .length   (length_q),
        .acc_ok   (acc_ok),
        .acc_strb (acc_strb)
    );

    cfg_window_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_req    (cfg_req),
        .cfg_write  (cfg_write),
        .cfg_sel    (sel_e),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .fld_rdata  (fld_rdata),
        .acc_ok     (acc_ok),
        .acc_strb   (acc_strb),
        .be_ack     (be_ack),
        .be_rdata   (be_rdata),
        .fld_we     (fld_we),
        .cfg_ready  (cfg_ready),
        .cfg_rdata  (cfg_rdata),
        .cfg_reject (cfg_reject),
        .be_req     (be_req),
        .be_we      (be_we),
        .be_wdata   (be_wdata),
        .be_strb    (be_strb)
    );

    cfg_window_regfile #(.BAR_SIZE(BAR_SIZE), .ACK_LAT(ACK_LAT)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .be_req   (be_req),
        .be_we    (be_we),
        .be_addr  (be_addr),
        .be_wdata (be_wdata),
        .be_strb  (be_strb),
        .be_ack   (be_ack),
        .be_rdata (be_rdata)
    );

endmodule

// File: rtl/cfg_window_bridge_sva.sv
// Checker: temporal properties of the bridge, bound into the top module.
module cfg_window_bridge_sva #(
    parameter int BAR_SIZE = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic [1:0]  cfg_sel,
    input logic        cfg_ready,
    input logic        cfg_reject,
    input logic        be_req,
    input logic        be_ack,
    input logic [31:0] be_addr,
    input logic [3:0]  be_strb
);

    // Backend strobe shape is one of the three legal lengths (R4).
    assert_strb_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (be_strb == 4'b0001 || be_strb == 4'b0011 || be_strb == 4'b1111));

    // Backend access stays inside the region (R3).
    assert_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (({1'b0, be_addr} + 33'($countones(be_strb))) <= 33'(BAR_SIZE)));

    // Backend address is aligned to the access length (R5).
    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> ((be_strb != 4'b1111 || be_addr[1:0] == 2'b00) &&
                    (be_strb != 4'b0011 || be_addr[0] == 1'b0)));

    // A backend request only opens after a window request (R8).
    assert_bus_from_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_req) |-> ($past(cfg_req) && $past(cfg_sel) == 2'd3));

    // Rejection shows only in a completion cycle (R8).
    assert_reject_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> cfg_ready);

    // Ready is a single-cycle strobe (R9).
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> !cfg_ready);

    // Host stays stalled while the backend is busy (R9).
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> !cfg_ready);

    // Backend request is held until acknowledged (R9).
    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> be_req);

    // Acknowledge ends the transaction and completes the host access (R9).
    assert_ack_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        be_ack |=> (cfg_ready && !be_req));

endmodule

bind cfg_window_bridge cfg_window_bridge_sva #(.BAR_SIZE(BAR_SIZE)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_req    (cfg_req),
    .cfg_sel    (cfg_sel),
    .cfg_ready  (cfg_ready),
    .cfg_reject (cfg_reject),
    .be_req     (be_req),
    .be_ack     (be_ack),
    .be_addr    (be_addr),
    .be_strb    (be_strb)
);

// File: tb/test_cfg_window_bridge.sv
// Bench: directed corners plus seeded random accesses, checked against a
// reference model of fields, window and register file.
module test_cfg_window_bridge;

    localparam int BAR_SIZE = 256;
    localparam int ACK_LAT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_write = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [3:0]  cfg_be = 4'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        cfg_ready;
    logic [31:0] cfg_rdata;
    logic        cfg_reject;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_mem [BAR_SIZE];
    logic [7:0]  m_region = 8'd0;
    logic [31:0] m_offset = 32'd0;
    logic [31:0] m_length = 32'd0;
    logic [31:0] m_win = 32'd0;

    always #5 clk = ~clk;

    cfg_window_bridge #(.BAR_SIZE(BAR_SIZE), .ACK_LAT(ACK_LAT)) i_cfg_window_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_req    (cfg_req),
        .cfg_write  (cfg_write),
        .cfg_sel    (cfg_sel),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_ready  (cfg_ready),
        .cfg_rdata  (cfg_rdata),
        .cfg_reject (cfg_reject)
    );

    function automatic logic [31:0] mask_of(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [3:0] strb_of(input logic [31:0] len);
        if (len == 32'd1) return 4'b0001;
        if (len == 32'd2) return 4'b0011;
        if (len == 32'd4) return 4'b1111;
        return 4'b0000;
    endfunction

    // Validity from R2..R5, computed at 33 bits.
    function automatic bit m_valid();
        logic [32:0] e;
        e = {1'b0, m_offset} + {1'b0, m_length};
        if (m_region != 8'd0) return 1'b0;
        if (strb_of(m_length) == 4'b0000) return 1'b0;
        if ((m_offset % m_length) != 0) return 1'b0;
        if (m_offset >= 32'(BAR_SIZE)) return 1'b0;
        return e <= 33'(BAR_SIZE);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One host access; expectations come from the model before it is updated.
    task automatic access(input logic w, input logic [1:0] s, input logic [3:0] be,
                          input logic [31:0] d, input string tag_in);
        logic [31:0] exp_rd;
        logic        exp_rej;
        int          exp_lat;
        int          lat;
        string       tag;
        logic [3:0]  st;
        logic [31:0] v;
        exp_rd = 32'd0;
        exp_rej = 1'b0;
        exp_lat = 1;
        st = strb_of(m_length);
        if (s != 2'd3) begin
            tag = "R1";
            if (w) begin
                if (s == 2'd0 && be[0]) m_region = d[7:0];
                if (s == 2'd1) m_offset = (m_offset & ~mask_of(be)) | (d & mask_of(be));
                if (s == 2'd2) m_length = (m_length & ~mask_of(be)) | (d & mask_of(be));
            end else begin
                v = (s == 2'd0) ? {24'd0, m_region} : (s == 2'd1) ? m_offset : m_length;
                exp_rd = v & mask_of(be);
            end
        end else if (!m_valid()) begin
            tag = "R8";
            exp_rej = 1'b1;
        end else if (w) begin
            tag = "R6";
            exp_lat = ACK_LAT + 1;
            m_win = (m_win & ~mask_of(be)) | (d & mask_of(be));
            for (int i = 0; i < 4; i++)
                if (st[i]) m_mem[int'(m_offset) + i] = m_win[8*i +: 8];
        end else begin
            tag = "R7";
            exp_lat = ACK_LAT + 1;
            v = 32'd0;
            for (int i = 0; i < 4; i++)
                if (st[i]) v[8*i +: 8] = m_mem[int'(m_offset) + i];
            m_win = v;
            exp_rd = v & mask_of(be);
        end
        if (tag_in != "") tag = tag_in;
        @(negedge clk);
        cfg_req = 1'b1;
        cfg_write = w;
        cfg_sel = s;
        cfg_be = be;
        cfg_wdata = d;
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (cfg_ready || lat > 40) break;
        end
        check(tag, "rdata", cfg_rdata, exp_rd);
        check(tag, "reject", 32'(cfg_reject), 32'(exp_rej));
        check("R9", "latency", 32'(lat), 32'(exp_lat));
        cfg_req = 1'b0;
        @(negedge clk);
        check("R9", "ready pulse", 32'(cfg_ready), 32'd0);
    endtask

    task automatic setup(input logic [7:0] r, input logic [31:0] o, input logic [31:0] l);
        access(1'b1, 2'd0, 4'hF, {24'd0, r}, "R1");
        access(1'b1, 2'd1, 4'hF, o, "R1");
        access(1'b1, 2'd2, 4'hF, l, "R1");
    endtask

    initial begin
        for (int i = 0; i < BAR_SIZE; i++) m_mem[i] = 8'd0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check("R9", "ready in reset", 32'(cfg_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ready after reset", 32'(cfg_ready), 32'd0);
        // R1 reset values of the fields.
        access(1'b0, 2'd0, 4'hF, 32'd0, "R1");
        access(1'b0, 2'd1, 4'hF, 32'd0, "R1");
        access(1'b0, 2'd2, 4'hF, 32'd0, "R1");
        // R4 zero length after reset is refused.
        access(1'b0, 2'd3, 4'hF, 32'd0, "R4");
        // R10 register file reads as zero after reset.
        setup(8'd0, 32'd0, 32'd4);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R10");
        // R6 partial host enables, full-length backend write.
        access(1'b1, 2'd3, 4'b0001, 32'hAABBCCDD, "R6");
        access(1'b0, 2'd3, 4'hF, 32'd0, "R6");
        // R6 length 1 writes one byte despite full enables.
        setup(8'd0, 32'd8, 32'd1);
        access(1'b1, 2'd3, 4'hF, 32'h11223344, "R6");
        setup(8'd0, 32'd8, 32'd4);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R6");
        // R7 short read clears upper window bytes; partial enables on return.
        setup(8'd0, 32'd9, 32'd1);
        access(1'b0, 2'd3, 4'b0011, 32'd0, "R7");
        // R2 non-zero selector refused; R8 the refused write changes nothing.
        setup(8'd1, 32'd0, 32'd4);
        access(1'b1, 2'd3, 4'hF, 32'hDEADBEEF, "R2");
        access(1'b0, 2'd3, 4'hF, 32'd0, "R2");
        setup(8'd0, 32'd0, 32'd4);
        access(1'b1, 2'd3, 4'b0010, 32'h00005500, "R8");
        access(1'b0, 2'd3, 4'hF, 32'd0, "R8");
        // R3 region bounds, including wrap-around of a huge offset.
        setup(8'd0, 32'd252, 32'd4);
        access(1'b1, 2'd3, 4'hF, 32'hCAFEF00D, "R3");
        access(1'b0, 2'd3, 4'hF, 32'd0, "R3");
        setup(8'd0, 32'd256, 32'd1);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R3");
        setup(8'd0, 32'd255, 32'd1);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R3");
        setup(8'd0, 32'hFFFF_FFFC, 32'd4);
        access(1'b1, 2'd3, 4'hF, 32'h1, "R3");
        // R5 alignment.
        setup(8'd0, 32'd2, 32'd4);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R5");
        setup(8'd0, 32'd2, 32'd2);
        access(1'b1, 2'd3, 4'hF, 32'h0000BEEF, "R5");
        access(1'b0, 2'd3, 4'hF, 32'd0, "R5");
        setup(8'd0, 32'd3, 32'd2);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R5");
        // R4 illegal lengths.
        setup(8'd0, 32'd0, 32'd3);
        access(1'b0, 2'd3, 4'hF, 32'd0, "R4");
        setup(8'd0, 32'd0, 32'd8);
        access(1'b1, 2'd3, 4'hF, 32'd7, "R4");
        // Random mix.
        for (int n = 0; n < 500; n++) begin
            logic [1:0]  s;
            logic [31:0] d;
            int          k;
            s = 2'($urandom % 4);
            k = int'($urandom % 10);
            d = $urandom;
            if (s == 2'd0) d = (k < 8) ? 32'd0 : 32'd1;
            if (s == 2'd1) d = (k < 7) ? 32'($urandom % 64) * 4 + 32'($urandom % 4)
                             : (k < 9) ? 32'(252 + $urandom % 6) : 32'hFFFF_FFFE;
            if (s == 2'd2) d = (k < 3) ? 32'd1 : (k < 6) ? 32'd2 : (k < 9) ? 32'd4 : 32'd3;
            access(1'($urandom % 2), s, (s == 2'd3) ? 4'($urandom % 16) : 4'hF, d, "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule